// File: doc/BRIEF.md
# Shadowed Configuration Register

A configuration register built to survive glitches and single faults. Software must write the same value twice in a row before it takes effect. The first write only stages the value. The second write either commits it or raises an update error. A read of the register cancels any half-finished write pair, so software can always resynchronise.

Next to the committed value, the block keeps a second copy stored bit-inverted. Every cycle it checks, over the implemented bits, that the two copies are still complements of each other. A disagreement raises a storage error. That error is sticky until reset, and from then on the register ignores writes.

Both error kinds can also be recorded in a small local alert-cause register. Each cause has its own enable. The cause bits are sticky and are cleared by writing ones. A fatal-lock input freezes the register against any further change. A fault-injection input lets the shadow copy be disturbed on purpose, so that the detector can be exercised.

Top module: `shadow_cfg_reg`

## Requirements
- R1: After reset, `cfgValue` equals `RESET_VAL & MASK`, `phaseStaged` is 0, `updateErr` and `storageErr` are 0, and `alertCause` is 0.
- R2: A write while `phaseStaged` is 0 sets `phaseStaged` to 1 on the next cycle and leaves `cfgValue` unchanged.
- R3: A write while `phaseStaged` is 1 whose data ANDed with `MASK` equals the staged data updates `cfgValue` to that masked data on the next cycle and returns `phaseStaged` to 0. Bits outside `MASK` always read as 0.
- R4: A write while `phaseStaged` is 1 whose masked data differs from the staged data does three things. It drives `updateErr` high for exactly the next cycle, it keeps `cfgValue`, and it returns `phaseStaged` to 0.
- R5: A read (`rdEn`) returns `phaseStaged` to 0 on the next cycle, so the following write counts as a first write and no update error occurs. When `rdEn` and `wrEn` are both high in the same cycle, the write is ignored.
- R6: When the inverted shadow copy differs from the committed value in any bit inside `MASK`, `storageErr` rises on the following cycle and stays high until reset. A disturbance confined to bits outside `MASK` raises no storage error.
- R7: While a storage mismatch or `storageErr` is present, writes neither stage nor commit, and `cfgValue` and `phaseStaged` do not change except through a read.
- R8: Once `fatalLock` has been high in any cycle, every write from that cycle until reset is ignored.
- R9: Bit 0 of `alertCause` records update errors and bit 1 records storage errors. A cause bit is set only when its enable input (`enUpdCause` or `enStoreCause`) is high in the cycle its event is seen. Bit 0 is set together with the `updateErr` pulse. Bit 1 is set one cycle after `storageErr` rises.
- R10: A cause bit stays set until a cycle with `causeClrEn` high and the matching `causeClrMask` bit set clears it. If the cause is being set in that same cycle, setting wins.
- R11: `shadowFlip` XORs its value into the shadow copy at the next clock edge, on top of any commit reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrData | input | WIDTH | Write data |
| rdEn | input | 1 | Register read strobe; cancels staging |
| fatalLock | input | 1 | Freezes the register until reset once seen high |
| shadowFlip | input | WIDTH | Fault injection: bits to invert in the shadow copy |
| enUpdCause | input | 1 | Enable for recording update errors |
| enStoreCause | input | 1 | Enable for recording storage errors |
| causeClrEn | input | 1 | Write strobe for clearing cause bits |
| causeClrMask | input | 2 | Cause bits to clear (1 clears) |
| cfgValue | output | WIDTH | Committed value, also the read data |
| phaseStaged | output | 1 | High while a first write is staged |
| updateErr | output | 1 | One-cycle pulse on a mismatched second write |
| storageErr | output | 1 | Sticky storage-corruption flag |
| alertCause | output | 2 | Sticky local alert causes: bit 0 update, bit 1 storage |

## Verification
The assertions assume that `rstN` is the only way out of a storage error or a lock, and that `shadowFlip` is zero except during deliberate fault injection. The stimulus follows both assumptions. It drives every input for a whole cycle from the falling edge and raises `shadowFlip` only for single cycles. It goes back through reset before any test that needs a clean, unlocked register. It also drives at most one write per cycle, so the single-pulse property on `updateErr` relies on the two-write rule inside the block and not on spacing in the stimulus.

// File: rtl/shadow_cfg_pkg.sv
package shadow_cfg_pkg;

  typedef enum logic {
    PH_IDLE   = 1'b0,
    PH_STAGED = 1'b1
  } phase_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic stage;     // capture masked write data into staging
    logic commit;    // copy staging into committed value and shadow
    logic mismatch;  // second write disagreed with staging
  } strobe_t;

  localparam int unsigned NumCauses  = 2;
  localparam int unsigned CauseUpd   = 0;
  localparam int unsigned CauseStore = 1;

endpackage

// File: rtl/shadow_cfg_ctrl.sv
module shadow_cfg_ctrl
  import shadow_cfg_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    wrEn,
  input  logic    rdEn,
  input  logic    fatalLock,
  input  logic    matchIn,
  input  logic    faultIn,
  output strobe_t strb,
  output logic    phaseStaged
);

  phase_e phaseQ, phaseD;
  logic   lockQ;
  logic   locked;
  logic   blocked;

  assign locked  = lockQ | fatalLock;
  assign blocked = locked | faultIn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lockQ <= 1'b0;
    end else if (fatalLock) begin
      lockQ <= 1'b1;
    end
  end

  always_comb begin
    strb   = '0;
    phaseD = phaseQ;
    if (rdEn) begin
      phaseD = PH_IDLE;
    end else if (wrEn && !blocked) begin
      if (phaseQ == PH_IDLE) begin
        strb.stage = 1'b1;
        phaseD     = PH_STAGED;
      end else begin
        phaseD = PH_IDLE;
        if (matchIn) begin
          strb.commit = 1'b1;
        end else begin
          strb.mismatch = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseQ <= PH_IDLE;
    end else begin
      phaseQ <= phaseD;
    end
  end

  assign phaseStaged = (phaseQ == PH_STAGED);

  // R8
  lock_blocks_chk: assert property (@(posedge clk) disable iff (!rstN)
    lockQ |-> !(strb.stage || strb.commit || strb.mismatch));

  // R5
  read_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdEn |=> (phaseQ == PH_IDLE));

endmodule

// File: rtl/shadow_cfg_datapath.sv
module shadow_cfg_datapath
  import shadow_cfg_pkg::*;
#(
  parameter int unsigned WIDTH     = 32,
  parameter logic [WIDTH-1:0] MASK      = {WIDTH{1'b1}},
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strb,
  input  logic [WIDTH-1:0] wrData,
  input  logic [WIDTH-1:0] shadowFlip,
  output logic             matchOut,
  output logic             faultOut,
  output logic [WIDTH-1:0] cfgValue,
  output logic             updateErr,
  output logic             storageErr
);

  localparam logic [WIDTH-1:0] ResetCommitted = RESET_VAL & MASK;
  localparam logic [WIDTH-1:0] ResetShadow    = ~ResetCommitted;

  logic [WIDTH-1:0] stagedQ;
  logic [WIDTH-1:0] committedQ;
  logic [WIDTH-1:0] shadowQ;
  logic [WIDTH-1:0] shadowD;
  logic [WIDTH-1:0] maskedWr;
  logic [WIDTH-1:0] bitBad;
  logic             corrupt;
  logic             storErrQ;
  logic             updErrQ;

  assign maskedWr = wrData & MASK;
  assign matchOut = (maskedWr == stagedQ);

  // Per-bit complement check, only on implemented bits
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    if (MASK[b]) begin : g_live
      assign bitBad[b] = ~(shadowQ[b] ^ committedQ[b]);
    end else begin : g_dead
      assign bitBad[b] = 1'b0;
    end
  end

  assign corrupt  = |bitBad;
  assign faultOut = corrupt | storErrQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stagedQ <= '0;
    end else if (strb.stage) begin
      stagedQ <= maskedWr;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      committedQ <= ResetCommitted;
    end else if (strb.commit) begin
      committedQ <= stagedQ;
    end
  end

  assign shadowD = (strb.commit ? ~stagedQ : shadowQ) ^ shadowFlip;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shadowQ <= ResetShadow;
    end else begin
      shadowQ <= shadowD;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      storErrQ <= 1'b0;
      updErrQ  <= 1'b0;
    end else begin
      storErrQ <= storErrQ | corrupt;
      updErrQ  <= strb.mismatch;
    end
  end

  assign cfgValue   = committedQ;
  assign updateErr  = updErrQ;
  assign storageErr = storErrQ;

  // R4
  upd_single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    updErrQ |=> !updErrQ);

  // R6
  storage_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    storErrQ |=> storErrQ);

  // R7
  storage_freezes_chk: assert property (@(posedge clk) disable iff (!rstN)
    storErrQ |=> $stable(committedQ));

  // R2
  stage_keeps_value_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.stage |=> $stable(committedQ));

  // R3
  unimplemented_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (committedQ & ~MASK) == '0);

endmodule

// File: rtl/shadow_cfg_cause.sv
module shadow_cfg_cause #(
  parameter int unsigned NUM = 2
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic [NUM-1:0] setIn,
  input  logic [NUM-1:0] enIn,
  input  logic           clrEn,
  input  logic [NUM-1:0] clrMask,
  output logic [NUM-1:0] causeQ
);

  for (genvar i = 0; i < NUM; i++) begin : g_cause
    logic setHit;
    logic clrHit;

    assign setHit = setIn[i] & enIn[i];
    assign clrHit = clrEn & clrMask[i];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        causeQ[i] <= 1'b0;
      end else if (setHit) begin
        causeQ[i] <= 1'b1;
      end else if (clrHit) begin
        causeQ[i] <= 1'b0;
      end
    end

    // R9
    cause_gated_chk: assert property (@(posedge clk) disable iff (!rstN)
      !enIn[i] |=> !$rose(causeQ[i]));

    // R10
    cause_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
      (causeQ[i] && !clrHit) |=> causeQ[i]);
  end

endmodule

// File: rtl/shadow_cfg_reg.sv
module shadow_cfg_reg
  import shadow_cfg_pkg::*;
#(
  parameter int unsigned WIDTH     = 32,
  parameter logic [WIDTH-1:0] MASK      = 32'h00FF_FFFF,
  parameter logic [WIDTH-1:0] RESET_VAL = 32'h0000_1234
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic [WIDTH-1:0]     wrData,
  input  logic                 rdEn,
  input  logic                 fatalLock,
  input  logic [WIDTH-1:0]     shadowFlip,
  input  logic                 enUpdCause,
  input  logic                 enStoreCause,
  input  logic                 causeClrEn,
  input  logic [NumCauses-1:0] causeClrMask,
  output logic [WIDTH-1:0]     cfgValue,
  output logic                 phaseStaged,
  output logic                 updateErr,
  output logic                 storageErr,
  output logic [NumCauses-1:0] alertCause
);

  strobe_t              strb;
  logic                 matchSig;
  logic                 faultSig;
  logic [NumCauses-1:0] causeSet;
  logic [NumCauses-1:0] causeEn;

  shadow_cfg_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .wrEn       (wrEn),
    .rdEn       (rdEn),
    .fatalLock  (fatalLock),
    .matchIn    (matchSig),
    .faultIn    (faultSig),
    .strb       (strb),
    .phaseStaged(phaseStaged)
  );

  shadow_cfg_datapath #(
    .WIDTH    (WIDTH),
    .MASK     (MASK),
    .RESET_VAL(RESET_VAL)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .wrData    (wrData),
    .shadowFlip(shadowFlip),
    .matchOut  (matchSig),
    .faultOut  (faultSig),
    .cfgValue  (cfgValue),
    .updateErr (updateErr),
    .storageErr(storageErr)
  );

  always_comb begin
    causeSet             = '0;
    causeEn              = '0;
    causeSet[CauseUpd]   = strb.mismatch;
    causeSet[CauseStore] = storageErr;
    causeEn[CauseUpd]    = enUpdCause;
    causeEn[CauseStore]  = enStoreCause;
  end

  shadow_cfg_cause #(
    .NUM(NumCauses)
  ) u_cause (
    .clk    (clk),
    .rstN   (rstN),
    .setIn  (causeSet),
    .enIn   (causeEn),
    .clrEn  (causeClrEn),
    .clrMask(causeClrMask),
    .causeQ (alertCause)
  );

endmodule

// File: tb/shadow_cfg_reg_bench.sv
`timescale 1ns/1ps
module shadow_cfg_reg_bench;

  localparam int unsigned W = 32;
  localparam logic [W-1:0] MASK = 32'h00FF_FFFF;
  localparam logic [W-1:0] RST  = 32'h0000_1234;

  typedef struct {
    string      tag;
    logic [W-1:0] cfg;
    logic       ph;
    logic       upd;
    logic       stor;
    logic [1:0] cause;
  } item_t;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         wrEn = 1'b0;
  logic [W-1:0] wrData = '0;
  logic         rdEn = 1'b0;
  logic         fatalLock = 1'b0;
  logic [W-1:0] shadowFlip = '0;
  logic         enUpdCause = 1'b0;
  logic         enStoreCause = 1'b0;
  logic         causeClrEn = 1'b0;
  logic [1:0]   causeClrMask = '0;
  logic [W-1:0] cfgValue;
  logic         phaseStaged;
  logic         updateErr;
  logic         storageErr;
  logic [1:0]   alertCause;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  item_t expQ[$];

  // reference state
  logic [W-1:0] mCfg, mShadow, mStaged;
  logic         mPh, mUpd, mStor, mLock;
  logic [1:0]   mCause;

  always #2 clk = ~clk;

  shadow_cfg_reg #(.WIDTH(W), .MASK(MASK), .RESET_VAL(RST)) u_shadow_cfg_reg (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdEn(rdEn),
    .fatalLock(fatalLock), .shadowFlip(shadowFlip), .enUpdCause(enUpdCause),
    .enStoreCause(enStoreCause), .causeClrEn(causeClrEn),
    .causeClrMask(causeClrMask), .cfgValue(cfgValue), .phaseStaged(phaseStaged),
    .updateErr(updateErr), .storageErr(storageErr), .alertCause(alertCause)
  );

  task automatic compare(input item_t e);
    checks++;
    if (cfgValue !== e.cfg || phaseStaged !== e.ph || updateErr !== e.upd ||
        storageErr !== e.stor || alertCause !== e.cause) begin
      errors++;
      $display("FAIL %s: got cfg=%h ph=%b upd=%b stor=%b cause=%b, exp cfg=%h ph=%b upd=%b stor=%b cause=%b",
               e.tag, cfgValue, phaseStaged, updateErr, storageErr, alertCause,
               e.cfg, e.ph, e.upd, e.stor, e.cause);
    end
  endtask

  // monitor: compare after each edge, away from it
  initial begin
    forever begin
      @(negedge clk);
      if (expQ.size() != 0) compare(expQ.pop_front());
    end
  end

  task automatic modelReset();
    mCfg = RST & MASK; mShadow = ~(RST & MASK); mStaged = '0;
    mPh = 0; mUpd = 0; mStor = 0; mLock = 0; mCause = '0;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 0; wrEn = 0; rdEn = 0; fatalLock = 0; shadowFlip = '0;
    causeClrEn = 0; causeClrMask = '0;
    repeat (2) @(negedge clk);
    modelReset();
    // R1 reset state
    compare('{"R1 reset", RST & MASK, 1'b0, 1'b0, 1'b0, 2'b00});
    rstN = 1;
  endtask

  // driver: one cycle of stimulus, then push expected outputs
  task automatic cyc(input string tag, input bit wr, input logic [W-1:0] d,
                     input bit rd, input bit lk, input logic [W-1:0] flip,
                     input bit clr, input logic [1:0] cm);
    logic   bad, blocked, updEv, storOld;
    item_t  e;
    @(negedge clk);
    wrEn = wr; wrData = d; rdEn = rd; fatalLock = lk; shadowFlip = flip;
    causeClrEn = clr; causeClrMask = cm;
    @(posedge clk);
    bad     = (((~mShadow) ^ mCfg) & MASK) != '0;
    blocked = mStor | bad | mLock | lk;
    storOld = mStor;
    updEv   = 0;
    if (rd) mPh = 0;
    else if (wr && !blocked) begin
      if (!mPh) begin
        mStaged = d & MASK; mPh = 1;
      end else begin
        mPh = 0;
        if ((d & MASK) == mStaged) begin
          mCfg = mStaged; mShadow = ~mStaged;
        end else updEv = 1;
      end
    end
    mUpd = updEv;
    if (clr) mCause = mCause & ~cm;
    if (updEv && enUpdCause) mCause[0] = 1'b1;
    if (storOld && enStoreCause) mCause[1] = 1'b1;
    mStor   = mStor | bad;
    mShadow = mShadow ^ flip;
    mLock   = mLock | lk;
    e = '{tag, mCfg, mPh, mUpd, mStor, mCause};
    expQ.push_back(e);
  endtask

  task automatic idle(input string tag);
    cyc(tag, 0, '0, 0, 0, '0, 0, 2'b00);
  endtask

  task automatic wr1(input string tag, input logic [W-1:0] d);
    cyc(tag, 1, d, 0, 0, '0, 0, 2'b00);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got no completion, exp completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    doReset();
    enUpdCause = 1; enStoreCause = 1;
    wr1("R2 first write stages", 32'h0000_00AA);
    wr1("R3 matching second write commits", 32'h0000_00AA);
    idle("R3 idle after commit");
    wr1("R2 stage with unmasked bits", 32'hFF12_3456);
    wr1("R3 commit masks unimplemented bits", 32'hAB12_3456);
    wr1("R2 stage B", 32'h0000_0B0B);
    wr1("R4 mismatch raises update error", 32'h0000_0C0C);
    idle("R4 pulse ends, R9 cause0 held");
    cyc("R10 clear cause0 by writing one", 0, '0, 0, 0, '0, 1, 2'b01);
    idle("R10 cause0 cleared");
    wr1("R2 stage before read", 32'h0000_1111);
    cyc("R5 read clears staging", 0, '0, 1, 0, '0, 0, 2'b00);
    wr1("R5 write after read is first write", 32'h0000_2222);
    wr1("R5 commit after read", 32'h0000_2222);
    wr1("R5 stage", 32'h0000_3333);
    cyc("R5 write with read is ignored", 1, 32'h0000_4444, 1, 0, '0, 0, 2'b00);
    wr1("R5 next write stages", 32'h0000_5555);
    enUpdCause = 0;
    wr1("R9 mismatch with cause disabled", 32'h0000_6666);
    idle("R9 cause0 stays clear");
    enUpdCause = 1;
    cyc("R6 flip outside mask", 0, '0, 0, 0, 32'h8000_0000, 0, 2'b00);
    idle("R6 no storage error for unmasked flip");
    wr1("R6 stage after unmasked flip", 32'h0000_7777);
    wr1("R6 commit after unmasked flip", 32'h0000_7777);
    cyc("R11 flip masked shadow bit", 0, '0, 0, 0, 32'h0000_0001, 0, 2'b00);
    wr1("R7 write blocked by mismatch, R6 flag rises", 32'h0000_8888);
    wr1("R7 write blocked, R9 cause1 set", 32'h0000_8888);
    idle("R6 storage error sticky");
    cyc("R10 clear loses to active storage cause", 0, '0, 0, 0, '0, 1, 2'b10);
    idle("R6 still flagged");
    doReset();
    wr1("R8 stage before lock", 32'h0000_0042);
    cyc("R8 lock cycle blocks write", 1, 32'h0000_0042, 0, 1, '0, 0, 2'b00);
    wr1("R8 write ignored after lock", 32'h0000_0042);
    wr1("R8 second write ignored after lock", 32'h0000_0042);
    cyc("R5 read still clears under lock", 0, '0, 1, 0, '0, 0, 2'b00);
    wr1("R8 stage ignored under lock", 32'h0000_0099);
    idle("R8 final");
    repeat (3) @(negedge clk);
    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule